// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block sits beside the pipeline of a small soft-core processor. It decides whether a pending event can be taken this cycle. It then computes, in one step, every piece of architectural state that changes when the core enters a handler. The events it arbitrates are an external interrupt, a break, a hardware exception, a misaligned data access and a memory-translation fault. The pipeline supplies the current program counter, the branch target and the machine status word. It also supplies the faulting address and three instruction-state flags: the instruction sits in a branch delay slot, an immediate-prefix word is pending, and the branch owning the slot was itself immediate-prefixed.

One clock edge after a request is accepted, the block drives a single entry record. The record holds the handler address, one register-file write (index and value), the new status word, the exception syndrome, the saved branch target, the fault address register, and a pulse that drops any load-reserve reservation. Each of the syndrome, branch-target and fault-address outputs has its own write strobe. A memory-translation fault that arrives while an earlier one is still being handled is not serviced. Instead it raises a fatal pulse. The return-from-exception pulse re-arms the block.

Top module: `exc_entry_seq`

## Requirements
- R1: An interrupt request is accepted only when status bit 1 (interrupt enable) is 1, status bits 9 (exception in progress) and 3 (break in progress) are 0, and neither the delay-slot flag nor the prefix-pending flag is set.
- R2: Interrupt entry writes the current PC to register 14, clears status bit 1 and sets the next PC to the vector base plus 0x10.
- R3: Break entry writes the current PC to register 16, sets status bit 3 and sets the next PC to the vector base plus 0x18.
- R4: Hardware-exception entry writes PC+4 to register 17, sets status bit 9, jumps to the vector base plus 0x20 and writes the syndrome with the supplied 5-bit code in bits 4:0. When the delay-slot flag is set, it also sets syndrome bit 12 and writes the branch target to the branch-target output.
- R5: On a translation fault, the value written to register 17 depends on the flags. It is PC-8 when the delay-slot flag and the prefixed-branch flag are both set. It is PC-4 when only the delay-slot flag is set, or when the prefix-pending flag is set. Otherwise it is PC. The next PC is the vector base plus 0x20 and status bit 9 is set.
- R6: The translation-fault syndrome code in bits 4:0 depends on the fault class and the access. A protection fault gives 17 for a fetch and 16 for data. A miss gives 19 for a fetch and 18 for data. The access code is 0 for fetch, 1 for load and 2 for store. Bit 10 is set for a store, bit 12 and the branch-target write follow the delay-slot flag, and the fault-address output receives the faulting address.
- R7: On every entry, the new status word has bit 14 equal to the old bit 13 and bit 12 equal to the old bit 11. Bits 13 and 11 are cleared. All bits not named by the entry kind are kept.
- R8: Every entry produces, one cycle after the request cycle, exactly one register-file write strobe and one reservation-clear pulse. After reset no strobe, entry or fatal pulse is driven.
- R9: With exceptions disabled by configuration, hardware-exception and misaligned-access requests are ignored, and lower-priority events are taken as if they were absent.
- R10: A translation fault requested after a translation-fault entry, with no return-from-exception pulse since, raises the fatal pulse and no entry is taken that cycle. An entry in the same cycle as the return pulse takes precedence over the re-arm.
- R11: Misaligned-access entry writes PC+4 to register 17, sets status bit 9 and jumps to the vector base plus 0x20. It writes a syndrome whose bits 4:0 are 1 and whose bits 11:5 carry the supplied 7-bit syndrome, with bit 12 and the branch-target write following the delay-slot flag. The fault-address output receives the faulting address.
- R12: Simultaneous requests are served by priority: translation fault, hardware exception, misaligned access, break, then interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 1 | External interrupt pending |
| brk_req | input | 1 | Break request |
| hwe_req | input | 1 | Hardware exception request |
| hwe_code | input | EC_W | Hardware exception cause code |
| ual_req | input | 1 | Misaligned data access request |
| ual_ess | input | ESS_W | Instruction-supplied syndrome bits for misaligned access |
| mmu_req | input | 1 | Translation fault request |
| mmu_miss | input | 1 | 1 = lookup miss, 0 = protection fault |
| mmu_acc | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| eret | input | 1 | Return-from-exception pulse, re-arms fault handling |
| pc_in | input | XLEN | Current program counter |
| btarget | input | XLEN | Pending branch target |
| fault_addr | input | XLEN | Faulting data/fetch address |
| msr_in | input | XLEN | Current machine status word |
| in_dslot | input | 1 | Instruction is in a branch delay slot |
| imm_pend | input | 1 | Immediate prefix pending |
| br_imm | input | 1 | Branch owning the delay slot was prefixed |
| take | output | 1 | Entry taken (record valid) |
| next_pc | output | XLEN | Handler address |
| rf_we | output | 1 | Register-file write strobe |
| rf_waddr | output | RIDX_W | Register-file write index |
| rf_wdata | output | XLEN | Register-file write value (return address) |
| msr_out | output | XLEN | New status word |
| esr_we | output | 1 | Syndrome write strobe |
| esr_out | output | XLEN | Syndrome value |
| btr_we | output | 1 | Branch-target save strobe |
| btr_out | output | XLEN | Saved branch target |
| ear_we | output | 1 | Fault-address write strobe |
| ear_out | output | XLEN | Saved fault address |
| resv_clr | output | 1 | Drop load-reserve reservation |
| fatal | output | 1 | Recursive translation fault detected |

## Verification
Assertions run on every cycle. They check that an accepted interrupt met its enable gate, that interrupt and break entries carry the right return value, vector and status bit, and that the mode bits always move into their shadow positions. They also check that an unmasked translation fault always wins, that a disabled configuration never enters through register 17 without a fault, and that a fatal pulse is never paired with an entry. Other behaviour is shown only by the bench's sweep, which crosses every request combination with each legal flag state and several status words, on both an enabled and a disabled instance. That covers exact syndrome encodings, the three-way return-address rollback, the branch-target and fault-address strobes, and the busy flag built up and cleared across successive vectors.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE,
        CAUSE_IRQ,
        CAUSE_BRK,
        CAUSE_HWE,
        CAUSE_UAL,
        CAUSE_MMU
    } cause_e;

    // status word bit positions; the shadow bits sit one above the live bits
    localparam int MSR_IE  = 1;
    localparam int MSR_BIP = 3;
    localparam int MSR_EIP = 9;
    localparam int MSR_UM  = 11;
    localparam int MSR_UMS = 12;
    localparam int MSR_VM  = 13;
    localparam int MSR_VMS = 14;

    // syndrome bit positions
    localparam int ESR_ST = 10;
    localparam int ESR_DS = 12;

    localparam logic [1:0] ACC_FETCH = 2'd0;
    localparam logic [1:0] ACC_LOAD  = 2'd1;
    localparam logic [1:0] ACC_STORE = 2'd2;

    localparam int EC_UNALIGNED  = 1;
    localparam int EC_PROT_DATA  = 16;
    localparam int EC_PROT_FETCH = 17;
    localparam int EC_MISS_DATA  = 18;
    localparam int EC_MISS_FETCH = 19;

    localparam int RIDX_IRQ = 14;
    localparam int RIDX_BRK = 16;
    localparam int RIDX_EXC = 17;

    localparam int VOFS_IRQ = 'h10;
    localparam int VOFS_BRK = 'h18;
    localparam int VOFS_EXC = 'h20;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
    import exc_entry_pkg::*;
#(
    parameter bit EXC_EN = 1'b1,
    parameter int XLEN   = 32
) (
    input  logic            irq_req,
    input  logic            brk_req,
    input  logic            hwe_req,
    input  logic            ual_req,
    input  logic            mmu_req,
    input  logic [XLEN-1:0] msr,
    input  logic            in_dslot,
    input  logic            imm_pend,
    input  logic            mmu_busy,
    output cause_e          cause,
    output logic            fatal
);

    logic irq_ok;
    logic hwe_ok;
    logic ual_ok;

    always_comb begin
        irq_ok = irq_req && msr[MSR_IE] && !msr[MSR_EIP] && !msr[MSR_BIP]
                 && !in_dslot && !imm_pend;
        hwe_ok = EXC_EN && hwe_req;
        ual_ok = EXC_EN && ual_req;
        fatal  = mmu_req && mmu_busy;

        if (fatal)        cause = CAUSE_NONE;
        else if (mmu_req) cause = CAUSE_MMU;
        else if (hwe_ok)  cause = CAUSE_HWE;
        else if (ual_ok)  cause = CAUSE_UAL;
        else if (brk_req) cause = CAUSE_BRK;
        else if (irq_ok)  cause = CAUSE_IRQ;
        else              cause = CAUSE_NONE;
    end

endmodule

// File: rtl/exc_retaddr.sv
module exc_retaddr
    import exc_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int RIDX_W = 5
) (
    input  cause_e            cause,
    input  logic [XLEN-1:0]   pc,
    input  logic              in_dslot,
    input  logic              imm_pend,
    input  logic              br_imm,
    output logic [RIDX_W-1:0] ridx,
    output logic [XLEN-1:0]   rdata,
    output logic [XLEN-1:0]   vofs
);

    logic [XLEN-1:0] rollback;

    always_comb begin
        // how far back the re-executed sequence starts
        if (in_dslot)      rollback = br_imm ? XLEN'(8) : XLEN'(4);
        else if (imm_pend) rollback = XLEN'(4);
        else               rollback = '0;

        ridx  = RIDX_W'(RIDX_EXC);
        rdata = pc + XLEN'(4);
        vofs  = XLEN'(VOFS_EXC);
        unique case (cause)
            CAUSE_IRQ: begin
                ridx  = RIDX_W'(RIDX_IRQ);
                rdata = pc;
                vofs  = XLEN'(VOFS_IRQ);
            end
            CAUSE_BRK: begin
                ridx  = RIDX_W'(RIDX_BRK);
                rdata = pc;
                vofs  = XLEN'(VOFS_BRK);
            end
            CAUSE_MMU: rdata = pc - rollback;
            default:   ;
        endcase
    end

endmodule

// File: rtl/exc_syndrome.sv
module exc_syndrome
    import exc_entry_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int EC_W  = 5,
    parameter int ESS_W = 7
) (
    input  cause_e           cause,
    input  logic             mmu_miss,
    input  logic [1:0]       mmu_acc,
    input  logic             in_dslot,
    input  logic [EC_W-1:0]  hwe_code,
    input  logic [ESS_W-1:0] ual_ess,
    output logic [XLEN-1:0]  esr,
    output logic             esr_we,
    output logic             btr_we,
    output logic             ear_we
);

    logic [EC_W-1:0] mmu_code;

    always_comb begin
        unique case ({mmu_miss, mmu_acc == ACC_FETCH})
            2'b00:   mmu_code = EC_W'(EC_PROT_DATA);
            2'b01:   mmu_code = EC_W'(EC_PROT_FETCH);
            2'b10:   mmu_code = EC_W'(EC_MISS_DATA);
            default: mmu_code = EC_W'(EC_MISS_FETCH);
        endcase

        esr    = '0;
        esr_we = 1'b0;
        btr_we = 1'b0;
        ear_we = 1'b0;
        unique case (cause)
            CAUSE_MMU: begin
                esr[EC_W-1:0] = mmu_code;
                esr[ESR_ST]   = (mmu_acc == ACC_STORE);
                esr_we        = 1'b1;
                ear_we        = 1'b1;
            end
            CAUSE_HWE: begin
                esr[EC_W-1:0] = hwe_code;
                esr_we        = 1'b1;
            end
            CAUSE_UAL: begin
                esr[EC_W-1:0]    = EC_W'(EC_UNALIGNED);
                esr[EC_W +: ESS_W] = ual_ess;
                esr_we           = 1'b1;
                ear_we           = 1'b1;
            end
            default: ;
        endcase
        if (esr_we) begin
            esr[ESR_DS] = in_dslot;
            btr_we      = in_dslot;
        end
    end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              RIDX_W   = 5,
    parameter int              EC_W     = 5,
    parameter int              ESS_W    = 7,
    parameter bit              EXC_EN   = 1'b1,
    parameter logic [XLEN-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              brk_req,
    input  logic              hwe_req,
    input  logic [EC_W-1:0]   hwe_code,
    input  logic              ual_req,
    input  logic [ESS_W-1:0]  ual_ess,
    input  logic              mmu_req,
    input  logic              mmu_miss,
    input  logic [1:0]        mmu_acc,
    input  logic              eret,
    input  logic [XLEN-1:0]   pc_in,
    input  logic [XLEN-1:0]   btarget,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [XLEN-1:0]   msr_in,
    input  logic              in_dslot,
    input  logic              imm_pend,
    input  logic              br_imm,
    output logic              take,
    output logic [XLEN-1:0]   next_pc,
    output logic              rf_we,
    output logic [RIDX_W-1:0] rf_waddr,
    output logic [XLEN-1:0]   rf_wdata,
    output logic [XLEN-1:0]   msr_out,
    output logic              esr_we,
    output logic [XLEN-1:0]   esr_out,
    output logic              btr_we,
    output logic [XLEN-1:0]   btr_out,
    output logic              ear_we,
    output logic [XLEN-1:0]   ear_out,
    output logic              resv_clr,
    output logic              fatal
);

    typedef struct packed {
        logic              take;
        logic [XLEN-1:0]   next_pc;
        logic              rf_we;
        logic [RIDX_W-1:0] rf_waddr;
        logic [XLEN-1:0]   rf_wdata;
        logic [XLEN-1:0]   msr;
        logic              esr_we;
        logic [XLEN-1:0]   esr;
        logic              btr_we;
        logic [XLEN-1:0]   btr;
        logic              ear_we;
        logic [XLEN-1:0]   ear;
        logic              resv_clr;
        logic              fatal;
        logic              mmu_busy;
        logic              primed;
    } entry_t;

    entry_t st_d, st_q;

    cause_e            cause_w;
    logic              fatal_w;
    logic [RIDX_W-1:0] ridx_w;
    logic [XLEN-1:0]   rdata_w;
    logic [XLEN-1:0]   vofs_w;
    logic [XLEN-1:0]   esr_w;
    logic              esr_we_w;
    logic              btr_we_w;
    logic              ear_we_w;

    exc_arbiter #(.EXC_EN(EXC_EN), .XLEN(XLEN)) u_arb (
        .irq_req (irq_req),
        .brk_req (brk_req),
        .hwe_req (hwe_req),
        .ual_req (ual_req),
        .mmu_req (mmu_req),
        .msr     (msr_in),
        .in_dslot(in_dslot),
        .imm_pend(imm_pend),
        .mmu_busy(st_q.mmu_busy),
        .cause   (cause_w),
        .fatal   (fatal_w)
    );

    exc_retaddr #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_ret (
        .cause   (cause_w),
        .pc      (pc_in),
        .in_dslot(in_dslot),
        .imm_pend(imm_pend),
        .br_imm  (br_imm),
        .ridx    (ridx_w),
        .rdata   (rdata_w),
        .vofs    (vofs_w)
    );

    exc_syndrome #(.XLEN(XLEN), .EC_W(EC_W), .ESS_W(ESS_W)) u_syn (
        .cause   (cause_w),
        .mmu_miss(mmu_miss),
        .mmu_acc (mmu_acc),
        .in_dslot(in_dslot),
        .hwe_code(hwe_code),
        .ual_ess (ual_ess),
        .esr     (esr_w),
        .esr_we  (esr_we_w),
        .btr_we  (btr_we_w),
        .ear_we  (ear_we_w)
    );

    always_comb begin
        st_d          = '0;
        st_d.primed   = 1'b1;
        st_d.fatal    = fatal_w;
        st_d.mmu_busy = st_q.mmu_busy;
        if (cause_w == CAUSE_MMU) st_d.mmu_busy = 1'b1;
        else if (eret)            st_d.mmu_busy = 1'b0;

        if (cause_w != CAUSE_NONE) begin
            st_d.take     = 1'b1;
            st_d.rf_we    = 1'b1;
            st_d.resv_clr = 1'b1;
            st_d.rf_waddr = ridx_w;
            st_d.rf_wdata = rdata_w;
            st_d.next_pc  = VEC_BASE + vofs_w;

            // move live mode bits into their shadows, then drop them
            st_d.msr          = msr_in;
            st_d.msr[MSR_VMS] = msr_in[MSR_VM];
            st_d.msr[MSR_UMS] = msr_in[MSR_UM];
            st_d.msr[MSR_VM]  = 1'b0;
            st_d.msr[MSR_UM]  = 1'b0;
            unique case (cause_w)
                CAUSE_IRQ: st_d.msr[MSR_IE]  = 1'b0;
                CAUSE_BRK: st_d.msr[MSR_BIP] = 1'b1;
                default:   st_d.msr[MSR_EIP] = 1'b1;
            endcase

            st_d.esr_we = esr_we_w;
            st_d.esr    = esr_w;
            st_d.btr_we = btr_we_w;
            st_d.btr    = btr_we_w ? btarget : '0;
            st_d.ear_we = ear_we_w;
            st_d.ear    = ear_we_w ? fault_addr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign take     = st_q.take;
    assign next_pc  = st_q.next_pc;
    assign rf_we    = st_q.rf_we;
    assign rf_waddr = st_q.rf_waddr;
    assign rf_wdata = st_q.rf_wdata;
    assign msr_out  = st_q.msr;
    assign esr_we   = st_q.esr_we;
    assign esr_out  = st_q.esr;
    assign btr_we   = st_q.btr_we;
    assign btr_out  = st_q.btr;
    assign ear_we   = st_q.ear_we;
    assign ear_out  = st_q.ear;
    assign resv_clr = st_q.resv_clr;
    assign fatal    = st_q.fatal;

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && take && rf_waddr == RIDX_W'(RIDX_IRQ)) |->
            $past(msr_in[MSR_IE] && !msr_in[MSR_EIP] && !msr_in[MSR_BIP]
                  && !in_dslot && !imm_pend)); // R1

    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && take && rf_waddr == RIDX_W'(RIDX_IRQ)) |->
            (rf_wdata == $past(pc_in) && !msr_out[MSR_IE]
             && next_pc == VEC_BASE + XLEN'(VOFS_IRQ))); // R2

    AST_BRK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && take && rf_waddr == RIDX_W'(RIDX_BRK)) |->
            (rf_wdata == $past(pc_in) && msr_out[MSR_BIP]
             && next_pc == VEC_BASE + XLEN'(VOFS_BRK))); // R3

    AST_MODE_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && take) |->
            (msr_out[MSR_VMS] == $past(msr_in[MSR_VM])
             && msr_out[MSR_UMS] == $past(msr_in[MSR_UM])
             && !msr_out[MSR_VM] && !msr_out[MSR_UM])); // R7

    AST_FAULT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && $past(mmu_req) && !fatal) |->
            (take && ear_we && rf_waddr == RIDX_W'(RIDX_EXC))); // R12

    AST_EXC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!EXC_EN && st_q.primed && take && rf_waddr == RIDX_W'(RIDX_EXC)) |->
            $past(mmu_req)); // R9

    AST_RECURSE_NO_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && fatal) |-> (!take && !rf_we && $past(mmu_req))); // R10

endmodule

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;
    import exc_entry_pkg::*;

    localparam logic [31:0] VBASE = 32'hFFFF_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 0, brk_req = 0, hwe_req = 0, ual_req = 0, mmu_req = 0;
    logic [4:0]  hwe_code = '0;
    logic [6:0]  ual_ess = '0;
    logic        mmu_miss = 0, eret = 0;
    logic [1:0]  mmu_acc = '0;
    logic [31:0] pc_in = '0, btarget = '0, fault_addr = '0, msr_in = '0;
    logic        in_dslot = 0, imm_pend = 0, br_imm = 0;

    logic        tk1, we1, ew1, bw1, aw1, rc1, ft1;
    logic [4:0]  wa1;
    logic [31:0] np1, wd1, ms1, es1, bt1, ea1;
    logic        tk0, we0, ew0, bw0, aw0, rc0, ft0;
    logic [4:0]  wa0;
    logic [31:0] np0, wd0, ms0, es0, bt0, ea0;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    bit busy_m = 0;

    always #10 clk = ~clk;

    exc_entry_seq #(.EXC_EN(1'b1), .VEC_BASE(VBASE)) u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .brk_req(brk_req),
        .hwe_req(hwe_req), .hwe_code(hwe_code), .ual_req(ual_req), .ual_ess(ual_ess),
        .mmu_req(mmu_req), .mmu_miss(mmu_miss), .mmu_acc(mmu_acc), .eret(eret),
        .pc_in(pc_in), .btarget(btarget), .fault_addr(fault_addr), .msr_in(msr_in),
        .in_dslot(in_dslot), .imm_pend(imm_pend), .br_imm(br_imm),
        .take(tk1), .next_pc(np1), .rf_we(we1), .rf_waddr(wa1), .rf_wdata(wd1),
        .msr_out(ms1), .esr_we(ew1), .esr_out(es1), .btr_we(bw1), .btr_out(bt1),
        .ear_we(aw1), .ear_out(ea1), .resv_clr(rc1), .fatal(ft1));

    exc_entry_seq #(.EXC_EN(1'b0), .VEC_BASE(VBASE)) u_exc_entry_seq_noexc (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .brk_req(brk_req),
        .hwe_req(hwe_req), .hwe_code(hwe_code), .ual_req(ual_req), .ual_ess(ual_ess),
        .mmu_req(mmu_req), .mmu_miss(mmu_miss), .mmu_acc(mmu_acc), .eret(eret),
        .pc_in(pc_in), .btarget(btarget), .fault_addr(fault_addr), .msr_in(msr_in),
        .in_dslot(in_dslot), .imm_pend(imm_pend), .br_imm(br_imm),
        .take(tk0), .next_pc(np0), .rf_we(we0), .rf_waddr(wa0), .rf_wdata(wd0),
        .msr_out(ms0), .esr_we(ew0), .esr_out(es0), .btr_we(bw0), .btr_out(bt0),
        .ear_we(aw0), .ear_out(ea0), .resv_clr(rc0), .fatal(ft0));

    task automatic cmp(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] msr_pat(input int s);
        case (s)
            0: return 32'h0000_0002;
            1: return 32'h0000_2802;
            2: return 32'h0000_0202;
            3: return 32'h0000_000A;
            4: return 32'h0000_5000;
            5: return 32'h0000_6002;
            6: return 32'h8000_1802;
            default: return 32'h0000_2A0A;
        endcase
    endfunction

    // expected entry computed from the requirements; cause: 0 none 1 irq 2 brk 3 hwe 4 ual 5 mmu
    task automatic check_dut(input bit en, input bit busy,
        input logic tk, input logic [31:0] np, input logic we, input logic [4:0] wa,
        input logic [31:0] wd, input logic [31:0] ms, input logic ew, input logic [31:0] es,
        input logic bw, input logic [31:0] bt, input logic aw, input logic [31:0] ea,
        input logic rc, input logic ft);
        int c;
        bit efat, irq_ok;
        logic [31:0] m, e, r;
        logic [4:0] idx;
        logic [31:0] vec;
        string rq;
        irq_ok = irq_req && msr_in[1] && !msr_in[9] && !msr_in[3] && !in_dslot && !imm_pend;
        efat = mmu_req && busy;
        if (efat)                c = 0;
        else if (mmu_req)        c = 5;
        else if (hwe_req && en)  c = 3;
        else if (ual_req && en)  c = 4;
        else if (brk_req)        c = 2;
        else if (irq_ok)         c = 1;
        else                     c = 0;
        rq = efat ? "R10" : (c == 0 ? (en ? "R1" : "R9") : "R12");
        vectors++;
        cmp(rq, "take", {31'b0, tk}, {31'b0, c != 0});
        cmp("R10", "fatal", {31'b0, ft}, {31'b0, efat});
        cmp("R8", "rf_we", {31'b0, we}, {31'b0, c != 0});
        cmp("R8", "resv_clr", {31'b0, rc}, {31'b0, c != 0});
        if (c == 0) begin
            cmp(rq, "esr_we idle", {31'b0, ew}, 32'd0);
            cmp(rq, "ear_we idle", {31'b0, aw}, 32'd0);
            cmp(rq, "btr_we idle", {31'b0, bw}, 32'd0);
            return;
        end
        m = msr_in;
        m[14] = msr_in[13]; m[12] = msr_in[11]; m[13] = 0; m[11] = 0;
        e = 0;
        case (c)
            1: begin m[1] = 0; idx = 14; r = pc_in; vec = VBASE + 32'h10; end
            2: begin m[3] = 1; idx = 16; r = pc_in; vec = VBASE + 32'h18; end
            3: begin m[9] = 1; idx = 17; r = pc_in + 4; vec = VBASE + 32'h20;
                     e = {27'b0, hwe_code}; end
            4: begin m[9] = 1; idx = 17; r = pc_in + 4; vec = VBASE + 32'h20;
                     e = 32'd1 | ({25'b0, ual_ess} << 5); end
            default: begin
                m[9] = 1; idx = 17; vec = VBASE + 32'h20;
                r = in_dslot ? pc_in - (br_imm ? 8 : 4) : (imm_pend ? pc_in - 4 : pc_in);
                e = (mmu_miss ? 32'd18 : 32'd16) + ((mmu_acc == 2'd0) ? 32'd1 : 32'd0);
                if (mmu_acc == 2'd2) e[10] = 1'b1;
            end
        endcase
        if (c >= 3) e[12] = in_dslot;
        rq = (c == 1) ? "R2" : (c == 2) ? "R3" : (c == 3) ? "R4" : (c == 4) ? "R11" : "R5";
        cmp(rq, "next_pc", np, vec);
        cmp(rq, "rf_waddr", {27'b0, wa}, {27'b0, idx});
        cmp(rq, "rf_wdata", wd, r);
        cmp("R7", "msr_out", ms, m);
        rq = (c == 5) ? "R6" : rq;
        cmp(rq, "esr_we", {31'b0, ew}, {31'b0, c >= 3});
        if (c >= 3) cmp(rq, "esr_out", es, e);
        cmp(rq, "btr_we", {31'b0, bw}, {31'b0, (c >= 3) && in_dslot});
        if (c >= 3 && in_dslot) cmp(rq, "btr_out", bt, btarget);
        cmp(rq, "ear_we", {31'b0, aw}, {31'b0, c >= 4});
        if (c >= 4) cmp(rq, "ear_out", ea, fault_addr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: idle after reset
        vectors++;
        cmp("R8", "reset take", {31'b0, tk1}, 32'd0);
        cmp("R8", "reset rf_we", {31'b0, we1}, 32'd0);
        cmp("R8", "reset fatal", {31'b0, ft1}, 32'd0);
        cmp("R8", "reset take off", {31'b0, tk0}, 32'd0);
        for (int k = 0; k < 1024; k++) begin
            bit nb;
            {mmu_req, ual_req, hwe_req, brk_req, irq_req} = k[4:0];
            case (k[6:5])
                2'd0: {in_dslot, imm_pend, br_imm} = 3'b000;
                2'd1: {in_dslot, imm_pend, br_imm} = 3'b100;
                2'd2: {in_dslot, imm_pend, br_imm} = 3'b010;
                default: {in_dslot, imm_pend, br_imm} = 3'b101;
            endcase
            msr_in     = msr_pat(k[9:7]);
            mmu_acc    = 2'((k / 7) % 3);
            mmu_miss   = k[2] ^ k[8];
            eret       = (k % 5 == 0);
            pc_in      = 32'h0000_4000 + (k << 4);
            btarget    = 32'h8000_0000 | (k << 2);
            fault_addr = 32'hA000_0000 + k * 3;
            hwe_code   = 5'((k * 7) & 31);
            ual_ess    = 7'((k * 13) & 127);
            @(negedge clk);
            check_dut(1'b1, busy_m, tk1, np1, we1, wa1, wd1, ms1, ew1, es1, bw1, bt1, aw1, ea1, rc1, ft1);
            check_dut(1'b0, busy_m, tk0, np0, we0, wa0, wd0, ms0, ew0, es0, bw0, bt0, aw0, ea0, rc0, ft0);
            nb = busy_m;
            if (mmu_req && !busy_m) nb = 1'b1;
            else if (eret)          nb = 1'b0;
            busy_m = nb;
        end
        {mmu_req, ual_req, hwe_req, brk_req, irq_req} = '0;
        eret = 1'b0;
        @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

endmodule